// File: doc/BRIEF.md
# Multi-Lane Serial Flash Bus Phase Sequencer

This block sits on the memory side of a serial flash port and follows the bus phase of the current transfer. An upstream opcode decoder sends one command class strobe while chip select is low. From that point the sequencer counts serial clock edges through the address (and mode) phase, the dummy phase and the data phase. At each step it tells the datapath which IO lanes to sample, when to shift data in or out, and which lanes the device may drive.

The serial clock is oversampled by the system clock `clk_i`. Rising and falling SCK edges are detected against the previous sample, so `sck_i`, `cs_ni` and `io_i` are treated as synchronous to `clk_i`. Input strobes are combinational and valid in the system cycle in which the edge is seen. Phase changes take effect on the following `clk_i` edge. A latency code selects the dummy cycle count through a small table that can be set by parameter.

Top module: `sfi_seq`

## Requirements
- R1: While `rst_ni` is low, and one clock after `cs_ni` is seen high from any phase, `phase_o` is 0 (standby), `oe_o` is 0 and neither strobe fires.
- R2: Class 0 (quad program) takes ADDR_BITS (24) rising SCK edges with `rx_bits_o` = {3'b0, io_i[0]}, then enters phase 4 (quad in), where each rising edge passes all four lanes on `rx_bits_o`.
- R3: Class 1 (quad output read) takes 24 address bits on IO0 only, then enters the dummy phase (5), then phase 7 (quad out) with `oe_o` = 4'hF.
- R4: Class 2 (quad I/O read) takes (ADDR_BITS+MODE_BITS)/4 = 8 rising edges in phase 2, with all four lanes on `rx_bits_o`, then enters the dummy phase 5.
- R5: The dummy phase lasts a number of rising SCK edges set by `lat_code_i`: 0→8, 1→4, 2→5, 3→6. During it `oe_o` is 0 and `shift_in_o` stays low.
- R6: Class 3 (dual output read) takes 24 address bits on IO0, then the dummy phase, then phase 8 with `oe_o` = 4'b0011. The phase holds until `cs_ni` rises.
- R7: Class 4 (double-rate read) shifts in IO0 on both rising and falling edges for ADDR_BITS+MODE_BITS (32) edges in phase 3. It then counts dummy cycles in phase 6 and enters phase 9 with `oe_o` = 4'b0010.
- R8: `shift_out_o` pulses on each falling SCK edge in phases 7 and 8, and on both edges in phase 9. `shift_in_o` never pulses while any `oe_o` bit is set.
- R9: `phase_o` encoding: 0 standby, 1 single address, 2 quad address, 3 double-rate address, 4 quad in, 5 dummy, 6 double-rate dummy, 7 quad out, 8 dual out, 9 double-rate out.
- R10: `cmd_valid_i` is ignored outside standby. The phase is unchanged until `cs_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCK |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| sck_i | input | 1 | Serial clock sample |
| cs_ni | input | 1 | Active-low chip select |
| io_i | input | 4 | IO lane input values |
| cmd_valid_i | input | 1 | One-cycle strobe of a decoded command class |
| cmd_cls_i | input | 3 | Command class 0..4 (see R2-R7) |
| lat_code_i | input | 2 | Dummy cycle code from configuration |
| phase_o | output | 4 | Current bus phase (R9) |
| oe_o | output | 4 | Per-lane output enable |
| shift_in_o | output | 1 | Capture strobe for input data |
| rx_bits_o | output | 4 | Lane values valid for capture, unused lanes zero |
| shift_out_o | output | 1 | Launch strobe for output data |

## Verification
On every cycle the assertions check these properties: the return to standby after chip select rises; the silence of the dummy phases; the exclusion between capture and drive; capture on both edges in the double-rate address phase; and the persistence of the output and non-standby phases. Only the bench scenarios can show the edge counts that move each class to its next phase and the mapping of each latency code to its dummy length. The same holds for which lanes reach `rx_bits_o` per class and the ignoring of a late command strobe. The reference model checks these against the outputs on every clock.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  typedef enum logic [3:0] {
    PH_STANDBY   = 4'd0,
    PH_ADDR_SGL  = 4'd1,
    PH_ADDR_QUAD = 4'd2,
    PH_ADDR_DDR  = 4'd3,
    PH_QUAD_IN   = 4'd4,
    PH_LAT       = 4'd5,
    PH_DDR_LAT   = 4'd6,
    PH_QUAD_OUT  = 4'd7,
    PH_DUAL_OUT  = 4'd8,
    PH_DDR_OUT   = 4'd9
  } phase_e;

  typedef enum logic [2:0] {
    CL_QPROG = 3'd0,
    CL_QOUT  = 3'd1,
    CL_QIO   = 3'd2,
    CL_DOUT  = 3'd3,
    CL_DDR   = 3'd4
  } cls_e;
endpackage

// File: rtl/sfi_sck_edge.sv
module sfi_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/sfi_lat_lut.sv
module sfi_lat_lut #(
  parameter int unsigned LAT_W   = 4,
  parameter logic [4*LAT_W-1:0] LAT_MAP = 16'h6548
) (
  input  logic [1:0]       code_i,
  output logic [LAT_W-1:0] cnt_o
);
  logic [LAT_W-1:0] tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign tab[g] = LAT_MAP[g*LAT_W +: LAT_W];
  end

  assign cnt_o = tab[code_i];
endmodule

// File: rtl/sfi_phase_fsm.sv
module sfi_phase_fsm
  import sfi_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 24,
  parameter int unsigned MODE_BITS = 8,
  parameter int unsigned LAT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_cls_i,
  input  logic [LAT_W-1:0] lat_cnt_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output phase_e           phase_o
);
  localparam int unsigned QIO_EDGES = (ADDR_BITS + MODE_BITS) / 4;
  localparam int unsigned DDR_EDGES = ADDR_BITS + MODE_BITS;
  localparam int unsigned CNT_W     = $clog2(DDR_EDGES + (1 << LAT_W) + 1);

  phase_e           phase_q;
  cls_e             cls_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic phase_e out_phase(cls_e c);
    case (c)
      CL_DOUT: return PH_DUAL_OUT;
      CL_DDR:  return PH_DDR_OUT;
      default: return PH_QUAD_OUT;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_STANDBY;
      cls_q   <= CL_QPROG;
      cnt_q   <= '0;
    end else if (cs_ni) begin
      phase_q <= PH_STANDBY;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_STANDBY: if (cmd_valid_i) begin
          cls_q <= cls_e'(cmd_cls_i);
          case (cls_e'(cmd_cls_i))
            CL_QIO: begin phase_q <= PH_ADDR_QUAD; cnt_q <= CNT_W'(QIO_EDGES); end
            CL_DDR: begin phase_q <= PH_ADDR_DDR;  cnt_q <= CNT_W'(DDR_EDGES); end
            default: begin phase_q <= PH_ADDR_SGL; cnt_q <= CNT_W'(ADDR_BITS); end
          endcase
        end
        PH_ADDR_SGL, PH_ADDR_QUAD: if (rise_i) begin
          if (cnt_q == CNT_W'(1)) begin
            if (cls_q == CL_QPROG)           phase_q <= PH_QUAD_IN;
            else if (lat_cnt_i == '0)        phase_q <= out_phase(cls_q);
            else begin phase_q <= PH_LAT; cnt_q <= CNT_W'(lat_cnt_i); end
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_ADDR_DDR: if (rise_i || fall_i) begin
          if (cnt_q == CNT_W'(1)) begin
            if (lat_cnt_i == '0) phase_q <= PH_DDR_OUT;
            else begin phase_q <= PH_DDR_LAT; cnt_q <= CNT_W'(lat_cnt_i); end
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_LAT, PH_DDR_LAT: if (rise_i) begin
          if (cnt_q == CNT_W'(1)) phase_q <= out_phase(cls_q);
          else                    cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase_o = phase_q;

  // output phases persist until chip select rises
  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && phase_q == PH_DUAL_OUT) |=> phase_q == PH_DUAL_OUT);

  // a busy phase never drops to standby while selected
  assert_cmd_standby_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && phase_q != PH_STANDBY) |=> phase_q != PH_STANDBY);
endmodule

// File: rtl/sfi_seq.sv
module sfi_seq
  import sfi_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 24,
  parameter int unsigned MODE_BITS = 8,
  parameter int unsigned LAT_W     = 4,
  parameter logic [4*LAT_W-1:0] LAT_MAP = 16'h6548
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic [3:0] io_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_cls_i,
  input  logic [1:0] lat_code_i,
  output logic [3:0] phase_o,
  output logic [3:0] oe_o,
  output logic       shift_in_o,
  output logic [3:0] rx_bits_o,
  output logic       shift_out_o
);
  logic             rise, fall;
  logic [LAT_W-1:0] lat_cnt;
  phase_e           phase;
  logic [3:0]       in_mask;

  sfi_sck_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sck_i(sck_i),
    .rise_o(rise), .fall_o(fall)
  );

  sfi_lat_lut #(.LAT_W(LAT_W), .LAT_MAP(LAT_MAP)) u_lut (
    .code_i(lat_code_i), .cnt_o(lat_cnt)
  );

  sfi_phase_fsm #(.ADDR_BITS(ADDR_BITS), .MODE_BITS(MODE_BITS), .LAT_W(LAT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_cls_i(cmd_cls_i), .lat_cnt_i(lat_cnt),
    .rise_i(rise), .fall_i(fall), .phase_o(phase)
  );

  always_comb begin
    oe_o    = 4'h0;
    in_mask = 4'h0;
    case (phase)
      PH_ADDR_SGL, PH_ADDR_DDR: in_mask = 4'b0001;
      PH_ADDR_QUAD, PH_QUAD_IN: in_mask = 4'b1111;
      PH_QUAD_OUT:              oe_o    = 4'b1111;
      PH_DUAL_OUT:              oe_o    = 4'b0011;
      PH_DDR_OUT:               oe_o    = 4'b0010;
      default: ;
    endcase
  end

  assign shift_in_o  = (in_mask != 4'h0) & (rise | (phase == PH_ADDR_DDR & fall));
  assign rx_bits_o   = shift_in_o ? (io_i & in_mask) : 4'h0;
  // data launched on falling SCK, both edges in double-rate output
  assign shift_out_o = (oe_o != 4'h0) & (fall | (phase == PH_DDR_OUT & rise));
  assign phase_o     = phase;

  assert_cs_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (phase_o == 4'd0 && oe_o == 4'h0));

  assert_lat_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_LAT || phase == PH_DDR_LAT) |-> (oe_o == 4'h0 && !shift_in_o));

  assert_no_contention_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_in_o |-> oe_o == 4'h0);

  assert_ddr_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_ADDR_DDR && fall) |-> shift_in_o);
endmodule

// File: tb/tb_sfi_seq.sv
module tb_sfi_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, cmd_v = 1'b0;
  logic [3:0] io = 4'h0;
  logic [2:0] cls = 3'd0;
  logic [1:0] lat = 2'd0;
  logic [3:0] phase, oe, rx;
  logic       sin, sout;

  sfi_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .io_i(io),
    .cmd_valid_i(cmd_v), .cmd_cls_i(cls), .lat_code_i(lat),
    .phase_o(phase), .oe_o(oe), .shift_in_o(sin), .rx_bits_o(rx), .shift_out_o(sout)
  );

  int checks = 0, fails = 0;
  int m_ph = 0, m_cnt = 0, m_cls = 0;
  bit m_sck = 0;
  int cycles = 0;

  function automatic int lat_of(int c);
    case (c) 0: return 8; 1: return 4; 2: return 5; default: return 6; endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      0: return "R1"; 1, 4: return "R2"; 2: return "R4"; 3, 6, 9: return "R7";
      5: return "R5"; 7: return "R3"; default: return "R6";
    endcase
  endfunction

  function automatic int out_of(int c);
    return (c == 3) ? 8 : (c == 4) ? 9 : 7;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // compare outputs with the model, then advance the model across the next edge
  task automatic tick();
    bit rise, fall, ddr_in, in_ph;
    int e_oe, e_mask, e_sin, e_sout;
    #1;
    rise = sck && !m_sck;
    fall = !sck && m_sck;
    if (rst_n) begin
      e_oe   = (m_ph == 7) ? 4'hF : (m_ph == 8) ? 4'h3 : (m_ph == 9) ? 4'h2 : 0;
      e_mask = (m_ph == 1 || m_ph == 3) ? 1 : (m_ph == 2 || m_ph == 4) ? 4'hF : 0;
      ddr_in = (m_ph == 3);
      in_ph  = (e_mask != 0);
      e_sin  = in_ph && (rise || (ddr_in && fall));
      e_sout = (e_oe != 0) && (fall || (m_ph == 9 && rise));
      chk(phase == 4'(m_ph), "R9", "phase", phase, m_ph);
      chk(oe == 4'(e_oe), tag_of(m_ph), "oe", oe, e_oe);
      chk(sin == 1'(e_sin), tag_of(m_ph), "shift_in", sin, e_sin);
      chk(rx == (e_sin ? (io & 4'(e_mask)) : 4'h0), tag_of(m_ph), "rx_bits", rx,
          e_sin ? (io & e_mask) : 0);
      chk(sout == 1'(e_sout), "R8", "shift_out", sout, e_sout);
    end
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_cls = 0; m_sck = 0;
    end else begin
      if (cs_n) begin m_ph = 0; m_cnt = 0; end
      else if (m_ph == 0) begin
        if (cmd_v) begin
          m_cls = cls;
          if (cls == 2) begin m_ph = 2; m_cnt = 8; end
          else if (cls == 4) begin m_ph = 3; m_cnt = 32; end
          else begin m_ph = 1; m_cnt = 24; end
        end
      end else if ((m_ph == 1 || m_ph == 2) && rise) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_cls == 0) m_ph = 4;
          else begin m_ph = 5; m_cnt = lat_of(lat); end
        end
      end else if (m_ph == 3 && (rise || fall)) begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 6; m_cnt = lat_of(lat); end
      end else if ((m_ph == 5 || m_ph == 6) && rise) begin
        m_cnt--;
        if (m_cnt == 0) m_ph = out_of(m_cls);
      end
      m_sck = sck;
    end
    @(negedge clk);
    #2;
  endtask

  task automatic sck_cyc(input logic [3:0] d);
    io = d; sck = 1'b1; tick(); tick();
    sck = 1'b0; tick(); tick();
  endtask

  task automatic start(input int c, input int l);
    cs_n = 1'b0; lat = 2'(l); cls = 3'(c); cmd_v = 1'b1; tick();
    cmd_v = 1'b0; tick();
  endtask

  task automatic finish_cmd();
    cs_n = 1'b1; tick();
    chk(phase == 4'd0 && oe == 4'h0, "R1", "idle after cs", {phase, oe}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); #2;
    repeat (3) tick();
    chk(phase == 4'd0 && oe == 4'h0 && !sin && !sout, "R1", "reset state", phase, 0);
    rst_n = 1'b1; tick(); tick();

    // R2 quad program: address on IO0, then quad data
    start(0, 0);
    io = 4'hF; sck = 1'b1; #1;
    chk(rx == 4'h1, "R2", "address lane IO0 only", rx, 1);
    tick(); tick(); sck = 1'b0; tick(); tick();
    for (int i = 1; i < 24; i++) sck_cyc(4'hE);
    chk(phase == 4'd4, "R2", "quad in phase", phase, 4);
    io = 4'hA; sck = 1'b1; #1;
    chk(rx == 4'hA && sin, "R2", "quad data capture", rx, 4'hA);
    tick(); tick(); sck = 1'b0; tick(); tick();
    sck_cyc(4'h5);
    finish_cmd();

    // R3 quad output read, code 1 -> 4 dummy cycles (R5)
    start(1, 1);
    for (int i = 0; i < 24; i++) sck_cyc(4'hF);
    chk(phase == 4'd5, "R3", "dummy after address", phase, 5);
    for (int i = 0; i < 3; i++) sck_cyc(4'hF);
    chk(phase == 4'd5 && oe == 4'h0, "R5", "still dummy at 3 of 4", phase, 5);
    sck_cyc(4'hF);
    chk(phase == 4'd7 && oe == 4'hF, "R3", "quad out", {phase, oe}, 8'h7F);
    sck = 1'b1; tick(); tick(); sck = 1'b0; #1;
    chk(sout, "R8", "launch on falling edge", sout, 1);
    tick(); tick();
    finish_cmd();

    // R4 quad I/O read, code 2 -> 5 dummy cycles
    start(2, 2);
    for (int i = 0; i < 8; i++) sck_cyc(4'h9);
    chk(phase == 4'd5, "R4", "dummy after 8 quad edges", phase, 5);
    for (int i = 0; i < 4; i++) sck_cyc(4'h0);
    chk(phase == 4'd5, "R5", "code 2 still dummy at 4", phase, 5);
    sck_cyc(4'h0);
    chk(phase == 4'd7, "R5", "code 2 ends after 5", phase, 7);
    finish_cmd();

    // R6 dual output read, code 0 -> 8 dummy cycles; R10 late command ignored
    start(3, 0);
    for (int i = 0; i < 24; i++) sck_cyc(4'h3);
    for (int i = 0; i < 7; i++) sck_cyc(4'h0);
    chk(phase == 4'd5, "R5", "code 0 still dummy at 7", phase, 5);
    sck_cyc(4'h0);
    chk(phase == 4'd8 && oe == 4'h3, "R6", "dual out", {phase, oe}, 8'h83);
    cls = 3'd0; cmd_v = 1'b1; tick(); cmd_v = 1'b0;
    for (int i = 0; i < 5; i++) sck_cyc(4'h0);
    chk(phase == 4'd8, "R10", "late command ignored", phase, 8);
    chk(phase == 4'd8, "R6", "dual out persists", phase, 8);
    finish_cmd();

    // R7 double-rate read, code 3 -> 6 dummy cycles
    start(4, 3);
    for (int i = 0; i < 15; i++) sck_cyc(4'h1);
    io = 4'hF; sck = 1'b1; tick(); tick(); sck = 1'b0; #1;
    chk(sin && rx == 4'h1, "R7", "capture on falling edge", rx, 1);
    tick(); tick();
    chk(phase == 4'd6, "R7", "double-rate dummy", phase, 6);
    for (int i = 0; i < 6; i++) sck_cyc(4'h0);
    chk(phase == 4'd9 && oe == 4'h2, "R7", "double-rate out", {phase, oe}, 8'h92);
    sck = 1'b1; #1;
    chk(sout, "R8", "launch on rising edge in double-rate out", sout, 1);
    tick(); tick(); sck = 1'b0; tick(); tick();
    finish_cmd();

    // R1 abort mid-address
    start(1, 1);
    for (int i = 0; i < 5; i++) sck_cyc(4'hF);
    chk(phase == 4'd1, "R1", "mid address", phase, 1);
    finish_cmd();

    // R1 reset mid-output
    start(2, 1);
    for (int i = 0; i < 12; i++) sck_cyc(4'h0);
    chk(phase == 4'd7, "R1", "quad out before reset", phase, 7);
    rst_n = 1'b0; #1;
    chk(phase == 4'd0 && oe == 4'h0, "R1", "async reset", {phase, oe}, 0);
    tick(); rst_n = 1'b1; cs_n = 1'b1; tick(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule